// File: doc/BRIEF.md
# IMA Transmit Cell Slot Scheduler

This block decides, slot by slot, which kind of cell each transmit link of an inverse-multiplexed ATM group sends. Every link belongs to one of several groups. Each group runs its own frame counter over M cell slots, and M is selected per group as 32, 64, 128 or 256. On each slot tick, every link emits one of three kinds of cell. It sends a control cell when the group's slot index equals the link's active offset. Otherwise it sends a user cell when the link is in IMA mode, user sending is on and its queue holds a cell. In all other cases it sends a filler cell.

Software spreads the control cells across the links of a group by giving each link an offset. The reference link normally uses 0 and the others use multiples of M/N. An offset written while the group is running takes effect only from the next frame. For each group the block also counts edits to the control cell content and can raise a sticky end-of-frame flag. Link identifiers are handled entirely outside this block, and nothing here checks that they are unique. Payload assembly and the line interface sit downstream, and they consume `cell_kind` when `cell_vld` is high.

Top module: `ima_tx_slot_sched`

## Requirements
- R1: Each group keeps a slot index that starts at 0 after reset and advances by one on every `slot_tick`. It returns to 0 after the tick on which it holds M-1, where M = 32 << `grp_msel` (code 0=32, 1=64, 2=128, 3=256). Any index at or above M-1 also ends the frame.
- R2: On a tick where the link's group slot index equals the link's active offset, `cell_kind` for that link reads 3 (control) in the following cycle, whatever the link's other inputs are.
- R3: The active offset of a link is 0 after reset. It is reloaded from `link_ofs` only on a tick that ends a frame of the link's group, so a mid-frame write has no effect until the next frame.
- R4: On a tick without a control cell, the link's `cell_kind` reads 2 (user) when `link_ima`, `link_usr_en` and `link_fifo_ne` are all 1. Otherwise it reads 1 (filler).
- R5: `cell_vld` is 1 in the cycle after a `slot_tick` and 0 otherwise. When `cell_vld` is 0, every link's `cell_kind` is 0.
- R6: An active offset of M or more never matches, so that link sends no control cell in that frame.
- R7: A group's change counter (8 bits, wrapping) increments by one in the cycle after its control bytes differ from their value in the previous cycle. After reset the previous value is taken as all zero.
- R8: A group's frame flag is set in the cycle after a frame-ending tick if its enable is 1. It then stays set until a clear strobe. When a set and a clear fall in the same cycle, the set wins.
- R9: After reset, `cell_vld`, every `cell_kind`, every change counter and every frame flag are 0.
- R10: Links follow the counter and M of the group selected by `link_grp`. A group code with no matching group selects group 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_tick | input | 1 | One pulse per cell slot, common to all links |
| grp_msel | input | 2*NUM_GROUPS | Frame length code per group |
| grp_irq_en | input | NUM_GROUPS | Frame flag enable per group |
| grp_irq_clr | input | NUM_GROUPS | Clear strobe for the frame flag per group |
| grp_ctl_bytes | input | 8*CTL_BYTES*NUM_GROUPS | Control cell content per group |
| link_grp | input | GW*NUM_LINKS | Group number per link |
| link_ofs | input | 8*NUM_LINKS | Requested control cell offset per link |
| link_ima | input | NUM_LINKS | Link in IMA mode |
| link_usr_en | input | NUM_LINKS | User cell sending enabled |
| link_fifo_ne | input | NUM_LINKS | User cell queue not empty |
| cell_vld | output | 1 | Slot decision valid |
| cell_kind | output | 2*NUM_LINKS | Per link: 0 none, 1 filler, 2 user, 3 control |
| grp_chg_cnt | output | 8*NUM_GROUPS | Change counter per group |
| grp_frm_irq | output | NUM_GROUPS | Sticky frame flag per group |

## Verification
The bench builds the block with four links, two groups and two control bytes per group. With two groups, links can run on different frame lengths at the same time, and a link can be moved between groups while both counters are mid-frame. The short 32-slot frame on one group gives many frame boundaries. That brings offset reloads, out-of-range offsets and flag clears that land on the same cycle as a set into reach within a few thousand cycles. The narrow control content makes single-byte edits and rewrites of an unchanged value easy to produce on purpose.

// File: rtl/ima_sched_pkg.sv
package ima_sched_pkg;

   localparam int unsigned SLOT_W  = 8;
   localparam int unsigned MSEL_W  = 2;
   localparam int unsigned BASE_M  = 32;

   typedef enum logic [1:0] {
      CK_NONE = 2'd0,
      CK_FILL = 2'd1,
      CK_USER = 2'd2,
      CK_CTRL = 2'd3
   } cell_kind_e;

   // index of the last slot in a frame for a given length code
   function automatic logic [SLOT_W-1:0] frame_last(input logic [MSEL_W-1:0] sel);
      logic [SLOT_W:0] len;
      len = (SLOT_W+1)'(BASE_M) << sel;
      return SLOT_W'(len - 1'b1);
   endfunction

endpackage

// File: rtl/ima_frame_ctr.sv
module ima_frame_ctr
   import ima_sched_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick,
   input  logic [MSEL_W-1:0]   msel,
   input  logic                irq_en,
   input  logic                irq_clr,
   output logic [SLOT_W-1:0]   slot,
   output logic                frame_end,
   output logic                irq_flag
);

   logic [SLOT_W-1:0] slot_q;
   logic              flag_q;
   logic [SLOT_W-1:0] last_idx;

   assign last_idx  = frame_last(msel);
   assign frame_end = tick && (slot_q >= last_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_q <= '0;
         flag_q <= 1'b0;
      end else begin
         if (frame_end)
            slot_q <= '0;
         else if (tick)
            slot_q <= slot_q + 1'b1;

         if (frame_end && irq_en)
            flag_q <= 1'b1;
         else if (irq_clr)
            flag_q <= 1'b0;
      end
   end

   assign slot     = slot_q;
   assign irq_flag = flag_q;

endmodule

// File: rtl/ima_chg_ctr.sv
module ima_chg_ctr #(
   parameter int unsigned BYTES = 4,
   parameter int unsigned CNT_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BYTES*8-1:0]   ctl,
   output logic [CNT_W-1:0]     count
);

   logic [BYTES*8-1:0] shadow_q;
   logic [BYTES-1:0]   byte_diff;
   logic [CNT_W-1:0]   cnt_q;

   for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign byte_diff[b] = (ctl[b*8 +: 8] != shadow_q[b*8 +: 8]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
         cnt_q    <= '0;
      end else begin
         shadow_q <= ctl;
         if (|byte_diff)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count = cnt_q;

endmodule

// File: rtl/ima_link_pick.sv
module ima_link_pick
   import ima_sched_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [SLOT_W-1:0]  slot,
   input  logic               frame_end,
   input  logic [SLOT_W-1:0]  ofs_in,
   input  logic               ima,
   input  logic               usr_en,
   input  logic               fifo_ne,
   output logic [1:0]         kind
);

   logic [SLOT_W-1:0] act_ofs_q;
   cell_kind_e        kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_ofs_q <= '0;
         kind_q    <= CK_NONE;
      end else begin
         if (frame_end)
            act_ofs_q <= ofs_in;

         if (!tick)
            kind_q <= CK_NONE;
         else if (slot == act_ofs_q)
            kind_q <= CK_CTRL;
         else if (ima && usr_en && fifo_ne)
            kind_q <= CK_USER;
         else
            kind_q <= CK_FILL;
      end
   end

   assign kind = kind_q;

endmodule

// File: rtl/ima_tx_slot_sched.sv
module ima_tx_slot_sched
   import ima_sched_pkg::*;
#(
   parameter int unsigned NUM_LINKS  = 4,
   parameter int unsigned NUM_GROUPS = 2,
   parameter int unsigned CTL_BYTES  = 4,
   localparam int unsigned GW    = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
   localparam int unsigned CHG_W = 8
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               slot_tick,
   input  logic [NUM_GROUPS*MSEL_W-1:0]       grp_msel,
   input  logic [NUM_GROUPS-1:0]              grp_irq_en,
   input  logic [NUM_GROUPS-1:0]              grp_irq_clr,
   input  logic [NUM_GROUPS*CTL_BYTES*8-1:0]  grp_ctl_bytes,
   input  logic [NUM_LINKS*GW-1:0]            link_grp,
   input  logic [NUM_LINKS*SLOT_W-1:0]        link_ofs,
   input  logic [NUM_LINKS-1:0]               link_ima,
   input  logic [NUM_LINKS-1:0]               link_usr_en,
   input  logic [NUM_LINKS-1:0]               link_fifo_ne,
   output logic                               cell_vld,
   output logic [NUM_LINKS*2-1:0]             cell_kind,
   output logic [NUM_GROUPS*CHG_W-1:0]        grp_chg_cnt,
   output logic [NUM_GROUPS-1:0]              grp_frm_irq
);

   if (NUM_LINKS < 1)  begin : g_bad_links  $error("NUM_LINKS must be at least 1");  end
   if (NUM_GROUPS < 1) begin : g_bad_groups $error("NUM_GROUPS must be at least 1"); end
   if (CTL_BYTES < 1)  begin : g_bad_bytes  $error("CTL_BYTES must be at least 1");  end
   if (NUM_GROUPS > NUM_LINKS) begin : g_bad_ratio
      $error("NUM_GROUPS must not exceed NUM_LINKS");
   end

   logic [SLOT_W-1:0]     g_slot [NUM_GROUPS];
   logic [NUM_GROUPS-1:0] g_fend;
   logic                  vld_q;

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      ima_frame_ctr u_frm (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (slot_tick),
         .msel      (grp_msel[g*MSEL_W +: MSEL_W]),
         .irq_en    (grp_irq_en[g]),
         .irq_clr   (grp_irq_clr[g]),
         .slot      (g_slot[g]),
         .frame_end (g_fend[g]),
         .irq_flag  (grp_frm_irq[g])
      );

      ima_chg_ctr #(.BYTES(CTL_BYTES), .CNT_W(CHG_W)) u_chg (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl   (grp_ctl_bytes[g*CTL_BYTES*8 +: CTL_BYTES*8]),
         .count (grp_chg_cnt[g*CHG_W +: CHG_W])
      );
   end

   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_lnk
      logic [GW-1:0]     gsel;
      logic [SLOT_W-1:0] l_slot;
      logic              l_fend;

      assign gsel = link_grp[l*GW +: GW];

      // unmatched group codes fall back to group 0
      always_comb begin
         l_slot = g_slot[0];
         l_fend = g_fend[0];
         for (int g = 0; g < NUM_GROUPS; g++) begin
            if (gsel == GW'(g)) begin
               l_slot = g_slot[g];
               l_fend = g_fend[g];
            end
         end
      end

      ima_link_pick u_pick (
         .clk       (clk),
         .rst_n     (rst_n),
         .tick      (slot_tick),
         .slot      (l_slot),
         .frame_end (l_fend),
         .ofs_in    (link_ofs[l*SLOT_W +: SLOT_W]),
         .ima       (link_ima[l]),
         .usr_en    (link_usr_en[l]),
         .fifo_ne   (link_fifo_ne[l]),
         .kind      (cell_kind[l*2 +: 2])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else        vld_q <= slot_tick;
   end

   assign cell_vld = vld_q;

endmodule

// File: rtl/ima_tx_slot_sched_chk.sv
module ima_tx_slot_sched_chk #(
   parameter int unsigned NUM_LINKS  = 4,
   parameter int unsigned NUM_GROUPS = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      slot_tick,
   input logic [NUM_GROUPS-1:0]     grp_irq_en,
   input logic [NUM_GROUPS-1:0]     grp_irq_clr,
   input logic [NUM_LINKS-1:0]      link_ima,
   input logic [NUM_LINKS-1:0]      link_usr_en,
   input logic [NUM_LINKS-1:0]      link_fifo_ne,
   input logic                      cell_vld,
   input logic [NUM_LINKS*2-1:0]    cell_kind,
   input logic [NUM_GROUPS*8-1:0]   grp_chg_cnt,
   input logic [NUM_GROUPS-1:0]     grp_frm_irq
);

   p_vld_follows_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slot_tick |=> cell_vld);

   p_vld_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !slot_tick |=> !cell_vld);

   for (genvar l = 0; l < NUM_LINKS; l++) begin : g_l
      p_kind_none_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !cell_vld |-> cell_kind[l*2 +: 2] == 2'd0);

      p_user_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
         slot_tick && !(link_ima[l] && link_usr_en[l] && link_fifo_ne[l])
         |=> cell_kind[l*2 +: 2] != 2'd2);

      p_kind_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
         cell_vld |-> cell_kind[l*2 +: 2] != 2'd0);
   end

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
      p_chg_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
         grp_chg_cnt[g*8 +: 8] != $past(grp_chg_cnt[g*8 +: 8])
         |-> grp_chg_cnt[g*8 +: 8] == $past(grp_chg_cnt[g*8 +: 8]) + 8'd1);

      p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
         grp_frm_irq[g] && !grp_irq_clr[g] |=> grp_frm_irq[g]);

      p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !grp_frm_irq[g] && !(slot_tick && grp_irq_en[g]) |=> !grp_frm_irq[g]);
   end

endmodule

bind ima_tx_slot_sched ima_tx_slot_sched_chk #(
   .NUM_LINKS  (NUM_LINKS),
   .NUM_GROUPS (NUM_GROUPS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .slot_tick    (slot_tick),
   .grp_irq_en   (grp_irq_en),
   .grp_irq_clr  (grp_irq_clr),
   .link_ima     (link_ima),
   .link_usr_en  (link_usr_en),
   .link_fifo_ne (link_fifo_ne),
   .cell_vld     (cell_vld),
   .cell_kind    (cell_kind),
   .grp_chg_cnt  (grp_chg_cnt),
   .grp_frm_irq  (grp_frm_irq)
);

// File: tb/sim_ima_tx_slot_sched.sv
module sim_ima_tx_slot_sched;

   localparam int PERIOD = 10;
   localparam int NL = 4;
   localparam int NG = 2;
   localparam int CB = 2;
   localparam int GW = 1;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 slot_tick = 1'b0;
   logic [NG*2-1:0]      grp_msel = '0;
   logic [NG-1:0]        grp_irq_en = '0;
   logic [NG-1:0]        grp_irq_clr = '0;
   logic [NG*CB*8-1:0]   grp_ctl_bytes = '0;
   logic [NL*GW-1:0]     link_grp = '0;
   logic [NL*8-1:0]      link_ofs = '0;
   logic [NL-1:0]        link_ima = '0;
   logic [NL-1:0]        link_usr_en = '0;
   logic [NL-1:0]        link_fifo_ne = '0;
   logic                 cell_vld;
   logic [NL*2-1:0]      cell_kind;
   logic [NG*8-1:0]      grp_chg_cnt;
   logic [NG-1:0]        grp_frm_irq;

   always #(PERIOD/2) clk = ~clk;

   ima_tx_slot_sched #(.NUM_LINKS(NL), .NUM_GROUPS(NG), .CTL_BYTES(CB)) u0 (
      .clk(clk), .rst_n(rst_n), .slot_tick(slot_tick),
      .grp_msel(grp_msel), .grp_irq_en(grp_irq_en), .grp_irq_clr(grp_irq_clr),
      .grp_ctl_bytes(grp_ctl_bytes), .link_grp(link_grp), .link_ofs(link_ofs),
      .link_ima(link_ima), .link_usr_en(link_usr_en), .link_fifo_ne(link_fifo_ne),
      .cell_vld(cell_vld), .cell_kind(cell_kind),
      .grp_chg_cnt(grp_chg_cnt), .grp_frm_irq(grp_frm_irq));

   // behavioural reference
   int            m_cnt  [NG];
   int            m_irq  [NG];
   int            m_chg  [NG];
   logic [CB*8-1:0] m_shadow [NG];
   int            m_aofs [NL];
   int            m_kind [NL];
   int            m_vld;

   int    n_checks = 0;
   int    n_fails  = 0;
   string phase = "R9";
   bit    done = 1'b0;

   function automatic int last_of(int g);
      return (32 << grp_msel[g*2 +: 2]) - 1;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < NG; g++) begin
            m_cnt[g] = 0; m_irq[g] = 0; m_chg[g] = 0; m_shadow[g] = '0;
         end
         for (int l = 0; l < NL; l++) begin m_aofs[l] = 0; m_kind[l] = 0; end
         m_vld = 0;
      end else begin
         for (int l = 0; l < NL; l++) begin
            int g;
            g = int'(link_grp[l*GW +: GW]);
            if (g >= NG) g = 0;
            if (slot_tick) begin
               if (m_cnt[g] == m_aofs[l]) m_kind[l] = 3;
               else if (link_ima[l] && link_usr_en[l] && link_fifo_ne[l]) m_kind[l] = 2;
               else m_kind[l] = 1;
               if (m_cnt[g] >= last_of(g)) m_aofs[l] = int'(link_ofs[l*8 +: 8]);
            end else begin
               m_kind[l] = 0;
            end
         end
         for (int g = 0; g < NG; g++) begin
            bit fe;
            fe = slot_tick && (m_cnt[g] >= last_of(g));
            if (fe && grp_irq_en[g]) m_irq[g] = 1;
            else if (grp_irq_clr[g]) m_irq[g] = 0;
            if (fe) m_cnt[g] = 0;
            else if (slot_tick) m_cnt[g] = m_cnt[g] + 1;
            if (grp_ctl_bytes[g*CB*8 +: CB*8] != m_shadow[g]) m_chg[g] = (m_chg[g] + 1) % 256;
            m_shadow[g] = grp_ctl_bytes[g*CB*8 +: CB*8];
         end
         m_vld = slot_tick;
      end
   end

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
      end
   endtask

   task automatic compare_all();
      chk(int'(cell_vld) == m_vld, "R5", "cell_vld", int'(cell_vld), m_vld);
      for (int l = 0; l < NL; l++) begin
         int a;
         string req;
         a = int'(cell_kind[l*2 +: 2]);
         req = (m_kind[l] == 3) ? "R2" : (m_kind[l] == 0) ? "R5" : "R4";
         chk(a == m_kind[l], req, $sformatf("cell_kind link %0d", l), a, m_kind[l]);
      end
      for (int g = 0; g < NG; g++) begin
         chk(int'(grp_frm_irq[g]) == m_irq[g], "R8", $sformatf("frame flag group %0d", g),
             int'(grp_frm_irq[g]), m_irq[g]);
         chk(int'(grp_chg_cnt[g*8 +: 8]) == m_chg[g], "R7", $sformatf("change count group %0d", g),
             int'(grp_chg_cnt[g*8 +: 8]), m_chg[g]);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
      compare_all();
   endtask

   task automatic rand_link_inputs();
      link_ima     = NL'($urandom);
      link_usr_en  = NL'($urandom) | NL'($urandom);
      link_fifo_ne = NL'($urandom);
   endtask

   task automatic run(input int n, input int tick_pct, input int clr_pct);
      for (int i = 0; i < n; i++) begin
         cyc();
         slot_tick = (($urandom % 100) < tick_pct);
         rand_link_inputs();
         for (int g = 0; g < NG; g++)
            grp_irq_clr[g] = (($urandom % 100) < clr_pct);
      end
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      chk(cell_vld == 1'b0, "R9", "cell_vld at reset", int'(cell_vld), 0);
      chk(cell_kind == '0, "R9", "cell_kind at reset", int'(cell_kind), 0);
      chk(grp_chg_cnt == '0, "R9", "change counters at reset", int'(grp_chg_cnt), 0);
      chk(grp_frm_irq == '0, "R9", "frame flags at reset", int'(grp_frm_irq), 0);
      rst_n = 1'b1;

      // R1/R2/R4: continuous ticks, links 0,1 on group 0 (M=32), 2,3 on group 1 (M=64)
      phase = "R1";
      grp_msel = {2'd1, 2'd0};
      link_grp = 4'b1100;
      link_ofs = {8'd32, 8'd0, 8'd16, 8'd0};
      grp_irq_en = 2'b11;
      run(400, 100, 0);

      // R3: mid-frame offset rewrites
      phase = "R3";
      for (int k = 0; k < 6; k++) begin
         run(13, 100, 0);
         link_ofs[8 +: 8]  = 8'($urandom % 32);
         link_ofs[24 +: 8] = 8'($urandom % 64);
      end

      // R6: offsets outside the frame
      phase = "R6";
      link_ofs = {8'd200, 8'd64, 8'd40, 8'd0};
      run(300, 100, 0);

      // R5: sparse ticks
      phase = "R5";
      link_ofs = {8'd48, 8'd0, 8'd8, 8'd0};
      run(600, 35, 0);

      // R7: control content edits
      phase = "R7";
      for (int k = 0; k < 40; k++) begin
         cyc();
         case (k % 4)
            0: grp_ctl_bytes[7:0]   = grp_ctl_bytes[7:0] + 8'd1;
            1: grp_ctl_bytes[31:24] = 8'($urandom);
            2: ;
            default: grp_ctl_bytes = grp_ctl_bytes;
         endcase
      end
      for (int k = 0; k < 300; k++) begin
         cyc();
         grp_ctl_bytes[15:0] = grp_ctl_bytes[15:0] ^ 16'(1 << (k % 16));
      end

      // R8: flag enable and clear strobes, including collisions with frame end
      phase = "R8";
      grp_irq_en = 2'b01;
      run(300, 100, 10);
      grp_irq_en = 2'b11;
      run(400, 100, 15);
      grp_irq_en = 2'b10;
      run(200, 60, 5);

      // R10: switch frame lengths and move links between groups
      phase = "R10";
      grp_irq_en = 2'b11;
      grp_msel = {2'd3, 2'd2};
      run(700, 100, 5);
      link_grp = 4'b0101;
      link_ofs = {8'd128, 8'd0, 8'd64, 8'd10};
      run(800, 100, 5);
      grp_msel = {2'd0, 2'd3};
      run(500, 90, 5);

      cyc();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule